// File: doc/BRIEF.md
# Address-Triggered Debug Event Counter

This block counts events during a debug measurement window. Software preloads a 31-bit down-counter, picks what it counts (every core clock, or every word the block passes to the trace stream), and arms it. A pulse from an external start-address comparator turns counting on. A pulse from an end-address comparator can raise a one-cycle debug exception request. Counting does not stop on its own, so the handler clears the run bit and reads the register. The elapsed event count is the preload minus the value read back.

The block also sits in the trace path. It accepts destination addresses on a valid/ready input and forwards each one on a valid/ready output stream. In counter-tagging mode, the counter value is appended after each address. An option also appends a 32-bit extension counter. In extended mode, that extension counter records how many times the main counter rolled over from zero.

The trace sequencer is a four-state machine:
- IDLE accepts an address and moves to ADDR.
- ADDR goes to CNT if tagging is on, otherwise back to IDLE.
- CNT goes to EXT if the extension option is on, otherwise back to IDLE.
- EXT returns to IDLE.

Every transition out of ADDR, CNT or EXT happens on an output handshake.

Top module: `dbg_evt_counter`

## Requirements
- R1: After reset, the control register (address 0), value register (address 1) and extension register (address 2) all read 0. The exception request is low, the trace output is not valid, and the trace input is ready.
- R2: The control register keeps only bits 0–5, 8 and 9. All other bits read 0. The value register is written from bits 30:0 and bit 31 always reads 0. Bit 9 (test) is storage only and has no effect.
- R3: With bit 1 (run) set and bit 2 (source) clear, the count decrements by one on every clock edge. With run clear, the count holds its value.
- R4: A start pulse sets the run bit on the next edge when bit 0 (arm) is set. It has no effect when arm is clear.
- R5: An end pulse with bit 3 (exception enable) set drives the exception request high for exactly the following cycle. With bit 3 clear, no request is raised. The count is left untouched in either case.
- R6: With bit 8 (extended) clear, a counted event at a count of 0 leaves the count at 0.
- R7: With bit 8 set, a counted event at a count of 0 reloads the count to 0x7FFF_FFFF and increments the extension register by one.
- R8: Each accepted address is emitted on the trace output. When bit 4 (tagging) is set, the address is followed on the very next handshake by a word holding the count value at the moment the address was accepted. When bit 4 is clear, only the address is emitted.
- R9: With bits 4 and 5 both set, the counter word is followed directly by the extension register value captured at the moment the address was accepted. Bit 5 has no effect while bit 4 is clear.
- R10: With bit 2 set, every output handshake (address, counter and extension words) is one counted event.
- R11: While the trace output is valid and not ready, it stays valid and its data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 value, 2 extension |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| start_hit | input | 1 | Start-address match pulse |
| end_hit | input | 1 | End-address match pulse |
| dbg_exc_req | output | 1 | Debug exception request, one cycle |
| tr_in_valid | input | 1 | Destination address offered |
| tr_in_addr | input | 32 | Destination address |
| tr_in_ready | output | 1 | Address accepted when high with valid |
| tr_out_valid | output | 1 | Trace word valid |
| tr_out_data | output | 32 | Trace word |
| tr_out_ready | input | 1 | Trace sink ready |

## Verification
Register writes, start pulses and count ticks each take effect on the single clock edge after the stimulus. The bench drives every input 1 ns after a rising edge and reads registers just before the falling edge, so each expected count is the number of rising edges elapsed since the write. The exception request is sampled in the cycle after the end pulse is taken and again one cycle later to confirm it has dropped. Trace words are due one cycle after acceptance, one word per handshake. A scoreboard queue filled by the driver task is popped by a monitor at each falling edge where valid and ready are both high, and the monitor also checks stalled words for stability.

// File: rtl/dbgcnt_pkg.sv
`timescale 1ns/1ps
package dbgcnt_pkg;
    // control register bit positions
    localparam int CB_ARM  = 0;
    localparam int CB_RUN  = 1;
    localparam int CB_SRC  = 2;
    localparam int CB_EXC  = 3;
    localparam int CB_TCNT = 4;
    localparam int CB_TEXT = 5;
    localparam int CB_EXT  = 8;
    localparam int CB_TEST = 9;
    localparam logic [15:0] CTRL_WMASK = 16'h033F;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_VAL  = 2'd1,
        RA_EXT  = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_ADDR,
        TS_CNT,
        TS_EXT
    } trc_state_e;
endpackage

// File: rtl/evt_count_core.sv
`timescale 1ns/1ps
module evt_count_core #(
    parameter int CW = 31,
    parameter int XW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ext_mode,
    input  logic          ld_cnt,
    input  logic          ld_ext,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [XW-1:0] ext_wdata,
    output logic [CW-1:0] cnt,
    output logic [XW-1:0] ext
);
    localparam logic [CW-1:0] RELOAD = {CW{1'b1}};

    logic at_zero;
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld_cnt) begin
            cnt <= cnt_wdata;
        end else if (tick) begin
            if (!at_zero)
                cnt <= cnt - 1'b1;
            else if (ext_mode)
                cnt <= RELOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ext <= '0;
        else if (ld_ext)
            ext <= ext_wdata;
        else if (tick && at_zero && ext_mode && !ld_cnt)
            ext <= ext + 1'b1;
    end

    // R3: one step down per counted event
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero && !ld_cnt) |=> (cnt == $past(cnt) - 1'b1));
    // R3: frozen without events
    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_cnt) |=> $stable(cnt));
    // R6: saturation at zero in regular mode
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !ext_mode && !ld_cnt) |=> (cnt == '0));
    // R7: rollover with extension increment
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && ext_mode && !ld_cnt && !ld_ext)
        |=> (cnt == RELOAD && ext == $past(ext) + 1'b1));
endmodule

// File: rtl/evt_trace_seq.sv
`timescale 1ns/1ps
module evt_trace_seq
    import dbgcnt_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_mode,
    input  logic          ext_opt,
    input  logic          in_valid,
    input  logic [DW-1:0] in_addr,
    output logic          in_ready,
    input  logic [CW-1:0] cnt_i,
    input  logic [DW-1:0] ext_i,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          word_taken
);
    localparam int PADW = DW - CW;

    trc_state_e state, nxt;
    logic [DW-1:0] addr_q, ext_q;
    logic [CW-1:0] cnt_q;
    logic          cm_q, xo_q;
    logic          accept;

    assign accept = (state == TS_IDLE) && in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_IDLE: if (in_valid)  nxt = TS_ADDR;
            TS_ADDR: if (out_ready) nxt = cm_q ? TS_CNT : TS_IDLE;
            TS_CNT:  if (out_ready) nxt = xo_q ? TS_EXT : TS_IDLE;
            TS_EXT:  if (out_ready) nxt = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ext_q  <= '0;
            cm_q   <= 1'b0;
            xo_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= in_addr;
            cnt_q  <= cnt_i;
            ext_q  <= ext_i;
            cm_q   <= cnt_mode;
            xo_q   <= cnt_mode & ext_opt;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        unique case (state)
            TS_IDLE: in_ready = 1'b1;
            TS_ADDR: begin out_valid = 1'b1; out_data = addr_q; end
            TS_CNT:  begin out_valid = 1'b1; out_data = {{PADW{1'b0}}, cnt_q}; end
            TS_EXT:  begin out_valid = 1'b1; out_data = ext_q; end
        endcase
    end

    assign word_taken = out_valid & out_ready;

    // R11: stalled word held
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8: never accept and emit together
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    // R8: an accepted address shows up on the next cycle
    p_addr_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_valid && out_data == $past(in_addr)));
endmodule

// File: rtl/dbg_evt_counter.sv
`timescale 1ns/1ps
module dbg_evt_counter
    import dbgcnt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          start_hit,
    input  logic          end_hit,
    output logic          dbg_exc_req,
    input  logic          tr_in_valid,
    input  logic [DW-1:0] tr_in_addr,
    output logic          tr_in_ready,
    output logic          tr_out_valid,
    output logic [DW-1:0] tr_out_data,
    input  logic          tr_out_ready
);
    localparam int CW = DW - 1;
    localparam int RW = 16;

    logic [RW-1:0] ctrl_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] ext;
    logic          wr_ctrl, wr_val, wr_ext;
    logic          word_taken, tick;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_val  = reg_wr && (reg_addr == RA_VAL);
    assign wr_ext  = reg_wr && (reg_addr == RA_EXT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= reg_wdata[RW-1:0] & CTRL_WMASK;
        else if (start_hit && ctrl_q[CB_ARM])
            ctrl_q[CB_RUN] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbg_exc_req <= 1'b0;
        else        dbg_exc_req <= end_hit & ctrl_q[CB_EXC];
    end

    assign tick = ctrl_q[CB_RUN] & (ctrl_q[CB_SRC] ? word_taken : 1'b1);

    evt_count_core #(.CW(CW), .XW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ext_mode  (ctrl_q[CB_EXT]),
        .ld_cnt    (wr_val),
        .ld_ext    (wr_ext),
        .cnt_wdata (reg_wdata[CW-1:0]),
        .ext_wdata (reg_wdata),
        .cnt       (cnt),
        .ext       (ext)
    );

    evt_trace_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_mode   (ctrl_q[CB_TCNT]),
        .ext_opt    (ctrl_q[CB_TEXT]),
        .in_valid   (tr_in_valid),
        .in_addr    (tr_in_addr),
        .in_ready   (tr_in_ready),
        .cnt_i      (cnt),
        .ext_i      (ext),
        .out_valid  (tr_out_valid),
        .out_data   (tr_out_data),
        .out_ready  (tr_out_ready),
        .word_taken (word_taken)
    );

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {{(DW-RW){1'b0}}, ctrl_q};
            RA_VAL:  reg_rdata = {1'b0, cnt};
            RA_EXT:  reg_rdata = ext;
            default: reg_rdata = '0;
        endcase
    end

    // R2: reserved control bits stay clear
    p_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == '0);
    // R4: armed start pulse turns counting on
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && ctrl_q[CB_ARM] && !wr_ctrl) |=> ctrl_q[CB_RUN]);
    // R5: request follows an enabled end pulse
    p_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_hit && ctrl_q[CB_EXC]) |=> dbg_exc_req);
    // R5: no request without an end pulse
    p_exc_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !end_hit |=> !dbg_exc_req);
endmodule

// File: tb/dbg_evt_counter_bench.sv
`timescale 1ns/1ps
module dbg_evt_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start_hit = 1'b0;
    logic        end_hit = 1'b0;
    logic        dbg_exc_req;
    logic        tr_in_valid = 1'b0;
    logic [31:0] tr_in_addr = '0;
    logic        tr_in_ready;
    logic        tr_out_valid;
    logic [31:0] tr_out_data;
    logic        tr_out_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [30:0] mdl_cnt;
    logic        bp_mode = 1'b0;
    logic [3:0]  lfsr = 4'b1001;
    logic        stall_prev = 1'b0;
    logic [31:0] stall_data = '0;

    always #2 clk = ~clk;  // 250 MHz

    dbg_evt_counter u_dbg_evt_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_hit(start_hit),
        .end_hit(end_hit), .dbg_exc_req(dbg_exc_req), .tr_in_valid(tr_in_valid),
        .tr_in_addr(tr_in_addr), .tr_in_ready(tr_in_ready),
        .tr_out_valid(tr_out_valid), .tr_out_data(tr_out_data),
        .tr_out_ready(tr_out_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [31:0] a, input bit cm, input bit xo, input logic [31:0] xv);
        bit acc;
        exp_q.push_back(a); tag_q.push_back("R8 address");
        if (cm) begin
            exp_q.push_back({1'b0, mdl_cnt}); tag_q.push_back("R8 counter");
            if (xo) begin
                exp_q.push_back(xv); tag_q.push_back("R9 extension");
            end
        end
        mdl_cnt = mdl_cnt - 31'(1 + int'(cm) + int'(cm & xo));
        tr_in_addr = a; tr_in_valid = 1'b1;
        do begin
            @(negedge clk); acc = tr_in_ready;
            @(posedge clk); #1;
        end while (!acc);
        tr_in_valid = 1'b0;
        while (exp_q.size() != 0) begin
            @(posedge clk); #1;
        end
    endtask

    // sink ready pattern
    always @(posedge clk) begin
        #1;
        tr_out_ready = bp_mode ? lfsr[0] : 1'b1;
        lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                chk(tr_out_valid && tr_out_data == stall_data, "R11 stall hold", tr_out_data, stall_data);
            if (tr_out_valid && tr_out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected word", tr_out_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(tr_out_data == e, t, tr_out_data, e);
                end
            end
            stall_prev = tr_out_valid && !tr_out_ready;
            stall_data = tr_out_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 value", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 ext", v, 0);
        chk(!dbg_exc_req && !tr_out_valid && tr_in_ready, "R1 outputs",
            {29'b0, dbg_exc_req, tr_out_valid, tr_in_ready}, 32'h1);

        // R2 masking
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk(v == 32'h033F, "R2 ctrl mask", v, 32'h033F);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v == 32'h7FFF_FFFF, "R2 value bit31", v, 32'h7FFF_FFFF);
        wr(2'd1, 32'd20);
        wr(2'd0, 32'h0200);
        tick_n(4);
        rd(2'd0, v); chk(v == 32'h0200, "R2 test bit", v, 32'h0200);
        rd(2'd1, v); chk(v == 20, "R2 test bit no effect", v, 20);

        // R3 clock counting and freeze
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h0002);
        tick_n(10);
        rd(2'd1, v); chk(v == 90, "R3 count", v, 90);
        wr(2'd0, 32'h0);
        rd(2'd1, v); chk(v == 89, "R3 stop", v, 89);
        tick_n(5);
        rd(2'd1, v); chk(v == 89, "R3 frozen", v, 89);

        // R6 saturation
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h0002);
        tick_n(6);
        rd(2'd1, v); chk(v == 0, "R6 saturate", v, 0);
        rd(2'd2, v); chk(v == 0, "R6 ext unchanged", v, 0);
        wr(2'd0, 32'h0);

        // R7 extended rollover
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h0102);
        tick_n(4);
        rd(2'd1, v); chk(v == 32'h7FFF_FFFE, "R7 reload", v, 32'h7FFF_FFFE);
        rd(2'd2, v); chk(v == 1, "R7 ext inc", v, 1);
        wr(2'd0, 32'h0);

        // R4 start pulse
        wr(2'd1, 32'd50);
        start_hit = 1'b1; @(posedge clk); #1; start_hit = 1'b0;
        rd(2'd0, v); chk(v == 0, "R4 unarmed ignored", v, 0);
        wr(2'd0, 32'h0001);
        tick_n(3);
        rd(2'd1, v); chk(v == 50, "R4 waits", v, 50);
        start_hit = 1'b1; @(posedge clk); #1; start_hit = 1'b0;
        rd(2'd0, v); chk(v == 32'h3, "R4 run set", v, 32'h3);
        rd(2'd1, v); chk(v == 50, "R4 first edge", v, 50);
        tick_n(5);
        rd(2'd1, v); chk(v == 45, "R4 counting", v, 45);
        wr(2'd0, 32'h0);

        // R5 exception request
        wr(2'd1, 32'd77);
        wr(2'd0, 32'h000E);
        end_hit = 1'b1; @(posedge clk); #1; end_hit = 1'b0;
        chk(dbg_exc_req == 1'b1, "R5 request", {31'b0, dbg_exc_req}, 1);
        tick_n(1);
        chk(dbg_exc_req == 1'b0, "R5 one cycle", {31'b0, dbg_exc_req}, 0);
        rd(2'd1, v); chk(v == 77, "R5 count kept", v, 77);
        wr(2'd0, 32'h0006);
        end_hit = 1'b1; @(posedge clk); #1; end_hit = 1'b0;
        chk(dbg_exc_req == 1'b0, "R5 disabled", {31'b0, dbg_exc_req}, 0);

        // R8 / R10 trace tagging with trace-word counting
        wr(2'd2, 32'd7);
        wr(2'd1, 32'd500); mdl_cnt = 31'd500;
        wr(2'd0, 32'h0016);
        send(32'hA000_0010, 1'b1, 1'b0, 32'd7);
        wr(2'd0, 32'h0026);  // ext option without tagging
        send(32'hA000_0020, 1'b0, 1'b0, 32'd7);
        rd(2'd1, v); chk(v == {1'b0, mdl_cnt}, "R10 words counted", v, {1'b0, mdl_cnt});

        // R9 / R10 / R11 extension words under back-pressure
        wr(2'd1, 32'd1000); mdl_cnt = 31'd1000;
        wr(2'd0, 32'h0036);
        send(32'hB000_0100, 1'b1, 1'b1, 32'd7);
        bp_mode = 1'b1;
        send(32'hB000_0200, 1'b1, 1'b1, 32'd7);
        send(32'hB000_0300, 1'b1, 1'b1, 32'd7);
        bp_mode = 1'b0;
        tick_n(1);
        rd(2'd1, v); chk(v == 32'd991, "R10 injected words counted", v, 32'd991);

        tick_n(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule